// File: doc/BRIEF.md
# Grouped Input Debounce Filter Bank

This block cleans up 32 asynchronous digital input lines that come from mechanical contacts or isolated field wiring. Every line is first brought into the clock domain by a two-flop synchronizer. A stability filter then lets the line's filtered level follow a new raw level only after that level has held for a programmed interval. Any return to the old level before the interval ends discards the progress made so far.

The lines are split into four banks of eight adjacent channels. Each bank has its own tick generator. A 3-bit code picks the tick period as a power-of-two multiple of the block clock, from 32 to 4096 cycles, which spans 8 µs to about 1 ms on a 4 MHz clock. All four codes sit in one write-only 32-bit setup word that is loaded through a single write strobe. The 32 filtered levels are presented together as one registered word for the read path.

Top module: `dbnc_bank`

## Requirements
- R1: Channels 8g to 8g+7 form bank g (g = 0..3). Each bank's interval is set only by its own code and does not affect the other banks.
- R2: Bank g's code is read from setup-word bits [8g+2:8g], that is [2:0], [10:8], [18:16] and [26:24]. Every other bit of the word is ignored.
- R3: Code n gives a bank tick period of 32·2^n clock cycles, so code 0 gives 32 cycles and code 7 gives 4096 cycles.
- R4: A filtered output takes a new level only after the synchronized input has differed from it during STABLE_TICKS (default 3) consecutive bank ticks. After a single raw step, the change appears between 2·P+3 and 3·P+2 cycles after the step, where P is the bank period.
- R5: If the synchronized input returns to the current filtered level, the pending count is cleared. A pulse shorter than the interval therefore never reaches the output.
- R6: While reset is high, all codes are 0 and each filtered output is loaded from its synchronized input, so a steady input appears unchanged right after reset.
- R7: Every write to the setup word restarts all bank tick generators from zero. With code 0 and an input that is already stable, the output change lands exactly 97 cycles after the last write edge. While writes repeat faster than one period, no output changes.
- R8: Filtered output bit k belongs to input k. Once held long enough, any 32-bit input pattern appears unchanged on the output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (4 MHz intended) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the setup word |
| cfg_wdata | input | 32 | Setup word holding four 3-bit bank codes |
| raw_in | input | 32 | Asynchronous raw input lines |
| filt_out | output | 32 | Registered filtered levels, bit k = input k |

## Verification
A wrong bank code or a mis-decoded field only shows up as a changed settling time. It is caught by measuring, for each bank, the number of cycles from a raw step to the output change. The allowed windows for neighbouring codes do not overlap. A prescaler that runs off phase, or a stability count that is not cleared, shifts an output edge by at least one cycle or lets a short pulse through. A cycle-accurate reference model compares the output word on every clock, so either fault is reported in the cycle it first reaches the port.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  // distance between neighbouring bank code fields in the setup word
  localparam int FIELD_STRIDE = 8;

  // tick period in cycles for a given base divider and code
  function automatic int period_of(input int base, input int code);
    return base << code;
  endfunction
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    meta_q <= d;
    stab_q <= meta_q;
  end

  assign q = stab_q;
endmodule

// File: rtl/dbnc_prescaler.sv
module dbnc_prescaler #(
  parameter int CODE_W   = 3,
  parameter int BASE_DIV = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int MAX_DIV = BASE_DIV << ((1 << CODE_W) - 1);
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W:0]   div_w;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_comb begin
    div_w = (CNT_W+1)'(BASE_DIV) << code;
    lim   = CNT_W'(div_w - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == lim) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan #(
  parameter int STABLE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sync_in,
  output logic level
);
  localparam int SC_W = $clog2(STABLE_TICKS + 1);
  localparam logic [SC_W-1:0] LAST = SC_W'(STABLE_TICKS - 1);

  logic [SC_W-1:0] run_q;
  logic            level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= sync_in;
      run_q   <= '0;
    end else if (sync_in == level_q) begin
      run_q <= '0;
    end else if (tick) begin
      if (run_q == LAST) begin
        level_q <= sync_in;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level = level_q;
endmodule

// File: rtl/dbnc_bank.sv
module dbnc_bank #(
  parameter int NUM_CH       = 32,
  parameter int GRP_CH       = 8,
  parameter int CODE_W       = 3,
  parameter int BASE_DIV     = 32,
  parameter int STABLE_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [NUM_CH-1:0] cfg_wdata,
  input  logic [NUM_CH-1:0] raw_in,
  output logic [NUM_CH-1:0] filt_out
);
  import dbnc_pkg::*;

  localparam int NUM_GRP = NUM_CH / GRP_CH;

  logic [CODE_W-1:0]  code_q [NUM_GRP];
  logic [NUM_GRP-1:0] grp_tick;
  logic [NUM_CH-1:0]  sync_w;
  logic [NUM_CH-1:0]  level_w;

  dbnc_sync #(.W(NUM_CH)) u_sync (
    .clk (clk),
    .d   (raw_in),
    .q   (sync_w)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst)
        code_q[g] <= '0;
      else if (cfg_we)
        code_q[g] <= cfg_wdata[g*FIELD_STRIDE +: CODE_W];
    end

    dbnc_prescaler #(.CODE_W(CODE_W), .BASE_DIV(BASE_DIV)) u_pre (
      .clk     (clk),
      .rst     (rst),
      .restart (cfg_we),
      .code    (code_q[g]),
      .tick    (grp_tick[g])
    );

    for (genvar c = 0; c < GRP_CH; c++) begin : g_ch
      dbnc_chan #(.STABLE_TICKS(STABLE_TICKS)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .tick    (grp_tick[g]),
        .sync_in (sync_w[g*GRP_CH + c]),
        .level   (level_w[g*GRP_CH + c])
      );
    end
  end

  assign filt_out = level_w;
endmodule

// File: rtl/dbnc_bank_chk.sv
module dbnc_bank_chk #(
  parameter int NUM_CH = 32,
  parameter int GRP_CH = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_we,
  input logic [NUM_CH-1:0]        raw_in,
  input logic [NUM_CH-1:0]        filt_out,
  input logic [NUM_CH/GRP_CH-1:0] grp_tick
);
  localparam int NUM_GRP = NUM_CH / GRP_CH;

  // R7: a setup write leaves every bank without a tick in the next cycle
  a_r7_write_restarts: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (grp_tick == '0));

  // R3: bank ticks are single-cycle pulses (period is at least 32)
  a_r3_tick_single: assert property (@(posedge clk) disable iff (rst)
    (grp_tick != '0) |=> ((grp_tick & $past(grp_tick)) == '0));

  // R4: a filtered bit moves only to the level its input had three cycles ago
  a_r4_follows_sync: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (filt_out != $past(filt_out))) |->
      (((filt_out ^ $past(filt_out)) & (filt_out ^ $past(raw_in, 3))) == '0));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    // R1: a bank's outputs change only right after that bank's own tick
    a_r1_bank_own_tick: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (filt_out[g*GRP_CH +: GRP_CH] != $past(filt_out[g*GRP_CH +: GRP_CH])))
        |-> $past(grp_tick[g]));
  end
endmodule

bind dbnc_bank dbnc_bank_chk #(.NUM_CH(NUM_CH), .GRP_CH(GRP_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .raw_in   (raw_in),
  .filt_out (filt_out),
  .grp_tick (grp_tick)
);

// File: tb/dbnc_bank_bench.sv
module dbnc_bank_bench;
  localparam int ST = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] raw_in = 32'hA5C3_0F96;
  logic [31:0] filt_out;

  int checks = 0;
  int errors = 0;
  int lat [4];

  always #2 clk = ~clk;

  dbnc_bank u_dbnc_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .raw_in(raw_in), .filt_out(filt_out)
  );

  // behavioural reference model, updated on each rising edge
  logic [31:0] m_s1, m_s2, m_filt;
  int m_code [4];
  int m_pre [4];
  bit m_tick [4];
  int m_run [32];

  always @(posedge clk) begin
    bit old_tick [4];
    for (int g = 0; g < 4; g++) old_tick[g] = m_tick[g];
    if (rst) begin
      for (int g = 0; g < 4; g++) begin m_code[g] = 0; m_pre[g] = 0; m_tick[g] = 0; end
      for (int k = 0; k < 32; k++) m_run[k] = 0;
      m_filt = m_s2;
    end else begin
      for (int k = 0; k < 32; k++) begin
        if (m_s2[k] == m_filt[k]) m_run[k] = 0;
        else if (old_tick[k/8]) begin
          if (m_run[k] == ST - 1) begin m_filt[k] = m_s2[k]; m_run[k] = 0; end
          else m_run[k]++;
        end
      end
      for (int g = 0; g < 4; g++) begin
        if (cfg_we) begin m_pre[g] = 0; m_tick[g] = 0; end
        else if (m_pre[g] == (32 << m_code[g]) - 1) begin m_pre[g] = 0; m_tick[g] = 1; end
        else begin m_pre[g]++; m_tick[g] = 0; end
      end
      if (cfg_we)
        for (int g = 0; g < 4; g++) m_code[g] = int'((cfg_wdata >> (8*g)) & 32'h7);
    end
    m_s2 = m_s1;
    m_s1 = raw_in;
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (filt_out !== m_filt) begin
        errors++;
        $display("FAIL R4/R8 model compare: actual %h expected %h", filt_out, m_filt);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_win(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cfg_write(input logic [31:0] v);
    cfg_wdata = v;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // apply a new raw word and time each bank's first full settling
  task automatic step_and_time(input logic [31:0] nv, input int maxc);
    logic [31:0] chg;
    chg = raw_in ^ nv;
    for (int g = 0; g < 4; g++) lat[g] = ((chg >> (8*g)) & 32'hFF) != 0 ? -1 : 0;
    raw_in = nv;
    for (int c = 1; c <= maxc; c++) begin
      @(negedge clk);
      for (int g = 0; g < 4; g++)
        if (lat[g] < 0 && (((filt_out ^ nv) & chg & (32'hFF << (8*g))) == 0)) lat[g] = c;
    end
  endtask

  function automatic int lo_of(input int p); return 2*p + 3; endfunction
  function automatic int hi_of(input int p); return 3*p + 2; endfunction

  initial begin
    wait_cyc(6);
    rst = 1'b0;
    @(negedge clk);
    // R6: steady input seen unchanged right after reset
    chk("R6 reset loads synced input", filt_out, 32'hA5C3_0F96);
    wait_cyc(200);
    chk("R6 default code holds level", filt_out, 32'hA5C3_0F96);

    // R3/R4: code 0 in bank 0
    step_and_time(raw_in ^ 32'h0000_0001, 200);
    chk_win("R3/R4 bank0 code0 latency", lat[0], lo_of(32), hi_of(32));

    // R1/R2: distinct codes per bank, reserved bits set to one
    cfg_write(32'hF8F8_F8F8 | 32'h0302_0100);
    step_and_time(raw_in ^ 32'h0101_0101, 900);
    chk_win("R1/R2 bank0 code0", lat[0], lo_of(32),  hi_of(32));
    chk_win("R1/R2 bank1 code1", lat[1], lo_of(64),  hi_of(64));
    chk_win("R1/R2 bank2 code2", lat[2], lo_of(128), hi_of(128));
    chk_win("R1/R2 bank3 code3", lat[3], lo_of(256), hi_of(256));

    // R3: largest code on bank 3, bank 0 stays at code 0
    cfg_write(32'h0700_0000);
    step_and_time(raw_in ^ 32'h8000_0080, 12400);
    chk_win("R3 bank3 code7", lat[3], lo_of(4096), hi_of(4096));
    chk_win("R1 bank0 unaffected by bank3", lat[0], lo_of(32), hi_of(32));

    // R5: short pulses on channel 1 never pass
    cfg_write(32'h0000_0000);
    begin
      logic [31:0] hold;
      logic [31:0] base;
      hold = filt_out;
      base = raw_in;
      for (int i = 0; i < 10; i++) begin
        raw_in = base ^ 32'h2; wait_cyc(20);
        raw_in = base;         wait_cyc(20);
      end
      raw_in = base ^ 32'h2; wait_cyc(50);
      raw_in = base;         wait_cyc(10);
      chk("R5 pulses rejected", filt_out, hold);
    end

    // R7: repeated writes hold the prescaler at zero
    begin
      logic [31:0] hold;
      hold = filt_out;
      raw_in = raw_in ^ 32'h4;
      wait_cyc(3);
      for (int i = 0; i < 10; i++) begin
        cfg_write(32'h0);
        wait_cyc(19);
      end
      chk("R7 no change during write storm", filt_out, hold);
      cfg_write(32'h0);
      wait_cyc(96);
      chk("R7 cycle 96 still old", filt_out, hold);
      wait_cyc(1);
      chk("R7 cycle 97 new level", filt_out, hold ^ 32'h4);
    end

    // R8: whole-word patterns
    cfg_write(32'h0101_0101);
    raw_in = 32'h1234_5678; wait_cyc(250);
    chk("R8 pattern 1", filt_out, 32'h1234_5678);
    raw_in = 32'hFFFF_0000; wait_cyc(250);
    chk("R8 pattern 2", filt_out, 32'hFFFF_0000);
    raw_in = 32'h0F0F_F0F0; wait_cyc(250);
    chk("R8 pattern 3", filt_out, 32'h0F0F_F0F0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule